// File: doc/BRIEF.md
# Interrupt Request and Priority Resolver

This block is the decision core of an eight-line interrupt controller. It records incoming requests in a pending register and tracks lines already being serviced in an in-service register. A sideband mask and a per-line trigger-type vector come from outside. Each cycle it searches the unmasked pending lines and compares the best one against the best in-service line. Both searches use a rotating priority base. When the pending line is strictly more urgent, it raises a registered interrupt output.

A one-cycle acknowledge strobe takes the current winner and reports it one cycle later. On that strobe the block updates the in-service and pending state. An edge-triggered line has its pending bit consumed. A level-triggered line stays pending. With automatic end-of-interrupt the in-service bit is never set, and the priority base may rotate to the line after the one just served. Register programming, vector numbering and cascading sit outside the block. They reach it as plain inputs, together with a load strobe for the rotation base.

Top module: `irq_prio_resolver`

## Requirements
- R1: An edge line (trig_level bit 0) sets its pending bit only in a cycle where the input is 1 and was 0 in the previous cycle. An input held high after its pending bit was consumed does not set it again.
- R2: A level line (trig_level bit 1) has its pending bit equal to the input sampled at the last clock edge.
- R3: Priority slot p belongs to line (p + prio_base) mod 8, and slot 0 is the most urgent. The acknowledged line reported on ack_line is the most urgent unmasked pending line.
- R4: A line whose irq_mask bit is 1 is still recorded in pending_o. It never causes int_req and is never acknowledged.
- R5: int_req is 1 only when the best unmasked pending slot is strictly more urgent than the best in-service slot.
- R6: When nested_casc is 1, in-service bit 2 is left out of the comparison of R5.
- R7: An acknowledge clears the winner's pending bit when it is an edge line. A level line keeps its pending bit.
- R8: An acknowledge with auto_eoi 0 sets the winner's in-service bit.
- R9: An acknowledge with auto_eoi 1 leaves in_service_o unchanged. If rotate_aeoi is also 1, prio_base becomes (winner + 1) mod 8, and this takes precedence over a base_load in the same cycle.
- R10: An acknowledge when no request would preempt returns ack_spurious 1 with ack_line 7. It leaves the pending bits that the acknowledge would otherwise consume, and in_service_o, unchanged.
- R11: Reset clears pending, in-service, input history, prio_base, int_req and ack_valid.
- R12: int_req is a register computed from the state before each edge. It drops one cycle after the pending state stops preempting.
- R13: base_load with base_val loads prio_base at the next edge when no rotating acknowledge happens.
- R14: ack_valid is 1 for exactly the cycle after int_ack was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 8 | Request inputs |
| irq_mask | input | 8 | 1 blocks a line from winning |
| trig_level | input | 8 | 1 = level line, 0 = edge line |
| auto_eoi | input | 1 | Acknowledge does not enter service |
| rotate_aeoi | input | 1 | Rotate base after an automatic end-of-interrupt |
| nested_casc | input | 1 | Ignore in-service line 2 in the comparison |
| base_load | input | 1 | Load the rotation base |
| base_val | input | 3 | Value for base_load |
| int_ack | input | 1 | Acknowledge strobe |
| int_req | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_line | output | 3 | Acknowledged line, 7 when spurious |
| ack_spurious | output | 1 | Acknowledge found no preempting line |
| pending_o | output | 8 | Pending register |
| in_service_o | output | 8 | In-service register |
| prio_base | output | 3 | Current rotation base |

## Verification
A wrong pending bit shows on pending_o at the next edge. It shows on int_req one edge later. A bad rotation base or search shows as the wrong ack_line in the cycle after the strobe. A wrong in-service update first shows as a missing or extra int_req when the next request arrives. It therefore needs a follow-up request of lower, equal and higher rotated priority to be seen. Nested mode is exposed only by a request on the cascade line while that line is already in service.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int unsigned DEF_LINES   = 8;
    localparam int unsigned DEF_CASCADE = 2;

    function automatic logic [DEF_LINES-1:0] line_bit(input logic [$clog2(DEF_LINES)-1:0] idx);
        line_bit = '0;
        line_bit[idx] = 1'b1;
    endfunction
endpackage

// File: rtl/irq_line_sampler.sv
module irq_line_sampler #(
    parameter int unsigned LINES = 8
) (
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] trig_level,
    input  logic [LINES-1:0] hist_q,
    input  logic [LINES-1:0] pend_q,
    input  logic [LINES-1:0] consume,
    output logic [LINES-1:0] pend_next,
    output logic [LINES-1:0] hist_next
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        // level lines track the input, edge lines latch a rising edge
        assign pend_next[i] = trig_level[i] ? irq_in[i]
                            : ((pend_q[i] & ~consume[i]) | (irq_in[i] & ~hist_q[i]));
        assign hist_next[i] = irq_in[i];
    end
endmodule

// File: rtl/irq_prio_search.sv
module irq_prio_search #(
    parameter int unsigned LINES = 8,
    localparam int unsigned IW   = $clog2(LINES)
) (
    input  logic [LINES-1:0] req,
    input  logic [IW-1:0]    base,
    output logic [IW:0]      slot,
    output logic [IW-1:0]    line
);
    logic [LINES-1:0] rotated;

    always_comb begin
        for (int p = 0; p < LINES; p++) begin
            rotated[p] = req[IW'(p) + base];
        end
    end

    always_comb begin
        slot = (IW+1)'(LINES);
        for (int p = LINES - 1; p >= 0; p--) begin
            if (rotated[p]) slot = (IW+1)'(p);
        end
    end

    assign line = slot[IW-1:0] + base;
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter int unsigned LINES   = DEF_LINES,
    parameter int unsigned CASCADE = DEF_CASCADE,
    localparam int unsigned IW     = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_in,
    input  logic [LINES-1:0] irq_mask,
    input  logic [LINES-1:0] trig_level,
    input  logic             auto_eoi,
    input  logic             rotate_aeoi,
    input  logic             nested_casc,
    input  logic             base_load,
    input  logic [IW-1:0]    base_val,
    input  logic             int_ack,
    output logic             int_req,
    output logic             ack_valid,
    output logic [IW-1:0]    ack_line,
    output logic             ack_spurious,
    output logic [LINES-1:0] pending_o,
    output logic [LINES-1:0] in_service_o,
    output logic [IW-1:0]    prio_base
);
    localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASCADE;
    localparam logic [IW-1:0]    SPUR_LINE = IW'(LINES - 1);

    typedef struct packed {
        logic [LINES-1:0] pend;
        logic [LINES-1:0] insvc;
        logic [LINES-1:0] hist;
        logic [IW-1:0]    base;
        logic             intr;
        logic             avld;
        logic             aspur;
        logic [IW-1:0]    aline;
    } state_t;

    state_t st_q, st_d;

    logic [LINES-1:0] cand, svc_view, win_bit, consume_v;
    logic [LINES-1:0] pend_next, hist_next;
    logic [IW:0]      cand_slot, svc_slot;
    logic [IW-1:0]    cand_line, svc_line;
    logic             preempt, take;

    assign cand     = st_q.pend & ~irq_mask;
    assign svc_view = st_q.insvc & ~(nested_casc ? CASC_BIT : '0);

    irq_prio_search #(.LINES(LINES)) u_cand (
        .req(cand), .base(st_q.base), .slot(cand_slot), .line(cand_line)
    );

    irq_prio_search #(.LINES(LINES)) u_svc (
        .req(svc_view), .base(st_q.base), .slot(svc_slot), .line(svc_line)
    );

    assign preempt   = cand_slot < svc_slot;
    assign take      = int_ack & preempt;
    assign win_bit   = LINES'(1) << cand_line;
    assign consume_v = take ? (win_bit & ~trig_level) : '0;

    irq_line_sampler #(.LINES(LINES)) u_samp (
        .irq_in(irq_in), .trig_level(trig_level), .hist_q(st_q.hist),
        .pend_q(st_q.pend), .consume(consume_v),
        .pend_next(pend_next), .hist_next(hist_next)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pend  = pend_next;
        st_d.hist  = hist_next;
        if (take && !auto_eoi) st_d.insvc = st_q.insvc | win_bit;
        if (take && auto_eoi && rotate_aeoi) begin
            st_d.base = cand_line + IW'(1);
        end else if (base_load) begin
            st_d.base = base_val;
        end
        st_d.intr  = preempt;
        st_d.avld  = int_ack;
        st_d.aspur = int_ack & ~preempt;
        st_d.aline = preempt ? cand_line : SPUR_LINE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign int_req      = st_q.intr;
    assign ack_valid    = st_q.avld;
    assign ack_line     = st_q.aline;
    assign ack_spurious = st_q.aspur;
    assign pending_o    = st_q.pend;
    assign in_service_o = st_q.insvc;
    assign prio_base    = st_q.base;
endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
    parameter int unsigned LINES = 8,
    localparam int unsigned IW   = $clog2(LINES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] irq_in,
    input logic [LINES-1:0] irq_mask,
    input logic [LINES-1:0] trig_level,
    input logic             auto_eoi,
    input logic             rotate_aeoi,
    input logic             int_ack,
    input logic             int_req,
    input logic             ack_valid,
    input logic [IW-1:0]    ack_line,
    input logic             ack_spurious,
    input logic [LINES-1:0] pending_o,
    input logic [LINES-1:0] in_service_o,
    input logic [IW-1:0]    prio_base
);
    logic warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> ((pending_o & $past(trig_level)) == ($past(irq_in) & $past(trig_level)))); // R2

    AST_INT_HAS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && int_req) |-> ($past(pending_o & ~irq_mask) != '0)); // R5

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && ack_valid) |-> $past(int_ack)); // R14

    AST_SPUR_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_spurious) |-> (ack_line == IW'(LINES - 1))); // R10

    AST_SPUR_KEEPS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && ack_valid && ack_spurious) |-> $stable(in_service_o)); // R10

    AST_SVC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && ack_valid && !ack_spurious && !$past(auto_eoi)) |-> in_service_o[ack_line]); // R8

    AST_AEOI_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && ack_valid && !ack_spurious && $past(auto_eoi && rotate_aeoi))
        |-> (prio_base == ack_line + IW'(1))); // R9
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.LINES(LINES)) u_chk (.*);

// File: tb/sim_irq_prio_resolver.sv
`timescale 1ns/1ps
module sim_irq_prio_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0, irq_mask = '0, trig_level = '0;
    logic       auto_eoi = 1'b0, rotate_aeoi = 1'b0, nested_casc = 1'b0;
    logic       base_load = 1'b0, int_ack = 1'b0;
    logic [2:0] base_val = '0;
    logic       int_req, ack_valid, ack_spurious;
    logic [2:0] ack_line, prio_base;
    logic [7:0] pending_o, in_service_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_prio_resolver u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_mask(irq_mask),
        .trig_level(trig_level), .auto_eoi(auto_eoi), .rotate_aeoi(rotate_aeoi),
        .nested_casc(nested_casc), .base_load(base_load), .base_val(base_val),
        .int_ack(int_ack), .int_req(int_req), .ack_valid(ack_valid),
        .ack_line(ack_line), .ack_spurious(ack_spurious), .pending_o(pending_o),
        .in_service_o(in_service_o), .prio_base(prio_base)
    );

    // {irq_in[22:15], mask[14:7], base[6:4], spurious[3], line[2:0]}
    localparam logic [22:0] VEC [8] = '{
        {8'h01, 8'h00, 3'd0, 1'b0, 3'd0},
        {8'h84, 8'h00, 3'd0, 1'b0, 3'd2},
        {8'h84, 8'h00, 3'd3, 1'b0, 3'd7},
        {8'h84, 8'h80, 3'd3, 1'b0, 3'd2},
        {8'hFF, 8'hFF, 3'd0, 1'b1, 3'd7},
        {8'h12, 8'h00, 3'd5, 1'b0, 3'd1},
        {8'h00, 8'h00, 3'd2, 1'b1, 3'd7},
        {8'h60, 8'h20, 3'd6, 1'b0, 3'd6}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        irq_in = '0; irq_mask = '0; trig_level = '0;
        auto_eoi = 0; rotate_aeoi = 0; nested_casc = 0; base_load = 0; int_ack = 0;
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check("R11 pending", pending_o, 8'h00);
        check("R11 in_service", in_service_o, 8'h00);
        check("R11 int_req", int_req, 0);
        check("R11 ack_valid", ack_valid, 0);
        check("R11 prio_base", prio_base, 0);

        // table: level lines, auto end-of-interrupt without rotation
        trig_level = 8'hFF; auto_eoi = 1'b1;
        for (int k = 0; k < 8; k++) begin
            irq_in = VEC[k][22:15]; irq_mask = VEC[k][14:7];
            base_val = VEC[k][6:4]; base_load = 1'b1;
            step();
            base_load = 1'b0;
            check("R2 R4 pending follows level", pending_o, VEC[k][22:15]);
            check("R13 base loaded", prio_base, VEC[k][6:4]);
            step();
            check("R5 int_req", int_req, !VEC[k][3]);
            int_ack = 1'b1;
            step();
            int_ack = 1'b0;
            check("R14 ack_valid", ack_valid, 1);
            check("R3 R4 ack_line", ack_line, VEC[k][2:0]);
            check("R10 ack_spurious", ack_spurious, VEC[k][3]);
            check("R7 level stays pending", pending_o, VEC[k][22:15]);
            check("R9 no service entry", in_service_o, 8'h00);
            step();
            check("R14 ack_valid single", ack_valid, 0);
        end

        // edge lines, normal end-of-interrupt
        do_reset();
        irq_in = 8'h08;
        step();
        check("R1 edge sets", pending_o, 8'h08);
        step();
        check("R5 int raised", int_req, 1);
        int_ack = 1'b1;
        step();
        int_ack = 1'b0;
        check("R3 ack line 3", ack_line, 3);
        check("R8 service set", in_service_o, 8'h08);
        check("R7 edge consumed", pending_o, 8'h00);
        step();
        check("R1 held high no retrigger", pending_o, 8'h00);
        check("R12 int drops", int_req, 0);
        irq_in = 8'h28;
        step(); step();
        check("R5 lower priority blocked", int_req, 0);
        check("R1 line 5 pending", pending_o, 8'h20);
        irq_in = 8'h2A;
        step(); step();
        check("R5 higher priority preempts", int_req, 1);
        int_ack = 1'b1;
        step();
        int_ack = 1'b0;
        check("R3 ack line 1", ack_line, 1);
        check("R8 service nested", in_service_o, 8'h0A);
        check("R7 line 5 kept", pending_o, 8'h20);

        // spurious acknowledge with nothing pending
        do_reset();
        int_ack = 1'b1;
        step();
        int_ack = 1'b0;
        check("R10 spurious flag", ack_spurious, 1);
        check("R10 spurious line", ack_line, 7);
        check("R10 service untouched", in_service_o, 8'h00);

        // cascade line in service, nested mode
        do_reset();
        irq_in = 8'h04;
        step(); step();
        int_ack = 1'b1;
        step();
        int_ack = 1'b0;
        check("R8 cascade in service", in_service_o, 8'h04);
        irq_in = 8'h00;
        step();
        irq_in = 8'h04;
        step(); step();
        check("R5 equal priority blocked", int_req, 0);
        nested_casc = 1'b1;
        step();
        check("R6 nested mode lets cascade through", int_req, 1);

        // level line with rotating automatic end-of-interrupt
        do_reset();
        trig_level = 8'h10; irq_in = 8'h10; auto_eoi = 1'b1; rotate_aeoi = 1'b1;
        step(); step();
        check("R5 level raises", int_req, 1);
        int_ack = 1'b1; base_load = 1'b1; base_val = 3'd0;
        step();
        int_ack = 1'b0; base_load = 1'b0;
        check("R9 rotate wins over load", prio_base, 5);
        check("R9 service untouched", in_service_o, 8'h00);
        check("R7 level kept", pending_o, 8'h10);
        irq_in = 8'h00;
        step();
        check("R2 level drops", pending_o, 8'h00);
        check("R12 int lags one cycle", int_req, 1);
        step();
        check("R12 int deasserted", int_req, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog act=0 exp=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule